// File: doc/BRIEF.md
# Parallel Flash Bus Interface Front End

This block is the device-side front end of a parallel flash memory with a 32-bit data bus and 19 address pins. A fast internal clock oversamples every bus pin through a multi-stage synchronizer. Edges on the control pins are found by comparing each sampled value with the one taken a cycle before. From those edges the block latches the address that reaches the array, and it captures write data together with its address as a command for a downstream command interpreter. It also decides whether the data bus drives, and what it drives: array data, the status byte, signature data or query data. The memory array, the command interpreter and any burst counter sit outside and are reached through plain ports.

The address latch is transparent while latch enable is low and nothing has locked it. A read locks it on the first rising edge of latch enable or the burst clock. A write locks it on the first rising edge of chip enable, write enable or latch enable. The lock is released when chip enable or latch enable falls, or when a write completes. A write completes on the first rising edge of write enable or chip enable. Its address and data then leave on a valid/ready stream. A command is held unchanged until `cmd_ready` is seen high with `cmd_valid`, and it leaves on that clock edge. A write that completes while an earlier command is still waiting is discarded. The block has no queue. While the reset pin is low the bus does not drive, no write is accepted, and any waiting command is dropped.

Top module: `flash_bus_front`

## Requirements
- R1: `dq_oe` is high exactly when the sampled pins show chip enable low, output enable low, output disable high and the reset pin high. Any one of chip enable high, output enable high, output disable low or reset pin low on its own keeps it low. Pin changes take effect within 4 clocks.
- R2: Whenever `dq_oe` is low, `dq_out` is all zeros.
- R3: While driving, `out_sel` picks the source: 0 gives `arr_data`, 1 gives `status_byte` on bits 7..0 with bits 31..8 zero, 2 gives `sig_data` and 3 gives `query_data`. `dq_out` follows a change of select or source one clock later.
- R4: While latch enable is low and the latch is unlocked, `rd_addr` follows the address pins.
- R5: In a read (write enable high, chip enable low), a rising edge of latch enable or of the burst clock locks `rd_addr` to the address present at that edge. Later address pin changes are ignored until chip enable or latch enable falls.
- R6: In a write, the address is taken at the first rising edge of chip enable, write enable or latch enable. An address locked early by latch enable is the one sent with the command.
- R7: A write completes at the first rising edge of write enable or chip enable. `cmd_valid` then rises with `cmd_addr` and `cmd_data` holding the address and the data pins at that edge.
- R8: Write enable and chip enable rising in the same sampled cycle produce a single command.
- R9: A command stays valid with stable address and data until accepted, and `cmd_valid` falls the cycle after acceptance. A write that completes while a command waits is dropped.
- R10: While the reset pin is low, `dq_oe` is low, a waiting command is dropped, and writes are ignored.
- R11: Completing a write releases the address lock, so with latch enable still low `rd_addr` follows the pins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rst_n | input | 1 | Internal active-low reset |
| pin_cs_n | input | 1 | Chip enable pin, active low |
| pin_oe_n | input | 1 | Output enable pin, active low |
| pin_od_n | input | 1 | Output disable pin; low forces no drive |
| pin_we_n | input | 1 | Write enable pin, active low |
| pin_le_n | input | 1 | Latch enable pin; low makes the latch transparent |
| pin_bclk | input | 1 | Burst clock pin |
| pin_rst_n | input | 1 | Reset / power-down pin, active low |
| pin_addr | input | 19 | Address pins |
| pin_dq_in | input | 32 | Data pins, input direction |
| dq_out | output | 32 | Data to drive on the pins |
| dq_oe | output | 1 | Drive enable for the data pins |
| rd_addr | output | 19 | Latched address to the array |
| out_sel | input | 2 | Output source select |
| arr_data | input | 32 | Array read data |
| status_byte | input | 8 | Status byte |
| sig_data | input | 32 | Signature data |
| query_data | input | 32 | Query table data |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| cmd_addr | output | 19 | Command address |
| cmd_data | output | 32 | Command data |

## Verification
A wrong lock bit shows up at `rd_addr` within four clocks. The output either stops following pins that it should track, or moves after a latch edge that should have frozen it. The write tests with latch enable held low show a lock that is never released. A broken write-phase flag shows as a missing, duplicated or late `cmd_valid`, or as a command that carries the wrong address or data. Faults in the drive decision or the source select reach `dq_oe` and `dq_out` a few clocks after the pins or the select change. The randomized pin sweep compares these outputs with a bench-side model.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;
  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_SIG    = 2'd2,
    SRC_QUERY  = 2'd3
  } out_src_e;

  localparam int CTL_CS  = 0;
  localparam int CTL_OE  = 1;
  localparam int CTL_OD  = 2;
  localparam int CTL_WE  = 3;
  localparam int CTL_LE  = 4;
  localparam int CTL_K   = 5;
  localparam int CTL_RST = 6;
  localparam int CTL_W   = 7;
  localparam logic [CTL_W-1:0] CTL_IDLE = 7'b0011111;
endpackage

// File: rtl/fbi_sync.sv
module fbi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/fbi_addr_latch.sv
module fbi_addr_latch #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live_i,
  input  logic [AW-1:0] pins_i,
  input  logic          cs_low_i,
  input  logic          le_low_i,
  input  logic          le_rise_i,
  input  logic          le_fall_i,
  input  logic          k_rise_i,
  input  logic          cs_rise_i,
  input  logic          cs_fall_i,
  input  logic          we_rise_i,
  input  logic          wr_ctx_i,
  input  logic          wr_done_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] cur_addr_o
);
  logic          lock_q;
  logic [AW-1:0] addr_q;
  logic          cap_wr, cap_rd, cap, release_lock;

  assign cap_wr = wr_ctx_i & (cs_rise_i | we_rise_i | le_rise_i);
  assign cap_rd = ~wr_ctx_i & cs_low_i & (le_rise_i | k_rise_i);
  assign cap    = live_i & ~lock_q & (cap_wr | cap_rd);
  assign release_lock = cs_fall_i | le_fall_i | wr_done_i | ~live_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      addr_q <= '0;
    end else begin
      lock_q <= (lock_q & ~release_lock) | (cap & ~release_lock);
      if (!live_i)
        addr_q <= '0;
      else if (!lock_q && (cap || le_low_i))
        addr_q <= pins_i;
    end
  end

  assign addr_o     = addr_q;
  assign cur_addr_o = lock_q ? addr_q : pins_i;

  // R5: a held lock freezes the latched address
  assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && $past(lock_q)) |-> $stable(addr_q));
endmodule

// File: rtl/fbi_write_capture.sv
module fbi_write_capture #(
  parameter int AW = 19,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live_i,
  input  logic          cs_low_i,
  input  logic          we_low_i,
  input  logic          we_rise_i,
  input  logic          cs_rise_i,
  input  logic [AW-1:0] cur_addr_i,
  input  logic [DW-1:0] dq_i,
  output logic          wr_ctx_o,
  output logic          wr_done_o,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_data_o
);
  logic          phase_q;
  logic          valid_q;
  logic [AW-1:0] caddr_q;
  logic [DW-1:0] cdata_q;
  logic          done, load, fire;

  assign wr_ctx_o = phase_q | (we_low_i & cs_low_i);
  assign done     = live_i & phase_q & (we_rise_i | cs_rise_i);
  assign fire     = valid_q & cmd_ready_i;
  assign load     = done & (~valid_q | cmd_ready_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      valid_q <= 1'b0;
      caddr_q <= '0;
      cdata_q <= '0;
    end else begin
      phase_q <= live_i & (phase_q | (we_low_i & cs_low_i)) & ~done;
      if (!live_i) begin
        valid_q <= 1'b0;
      end else if (load) begin
        valid_q <= 1'b1;
        caddr_q <= cur_addr_i;
        cdata_q <= dq_i;
      end else if (fire) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign wr_done_o   = done;
  assign cmd_valid_o = valid_q;
  assign cmd_addr_o  = caddr_q;
  assign cmd_data_o  = cdata_q;

  // R9: a stalled command keeps its payload
  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !cmd_ready_i && live_i) |=> (valid_q && $stable(caddr_q) && $stable(cdata_q)));
  // R9: acceptance with no new write retires the command
  assert_cmd_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !done) |=> !valid_q);
endmodule

// File: rtl/fbi_out_mux.sv
module fbi_out_mux #(
  parameter int DW = 32,
  parameter int SW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      drive_i,
  input  flash_bus_pkg::out_src_e   src_i,
  input  logic [DW-1:0]             arr_i,
  input  logic [SW-1:0]             status_i,
  input  logic [DW-1:0]             sig_i,
  input  logic [DW-1:0]             query_i,
  output logic [DW-1:0]             dq_o,
  output logic                      oe_o
);
  import flash_bus_pkg::*;
  localparam int PADW = DW - SW;

  logic [DW-1:0] pick;
  logic [DW-1:0] dq_q;
  logic          oe_q;

  always_comb begin
    unique case (src_i)
      SRC_ARRAY:  pick = arr_i;
      SRC_STATUS: pick = {{PADW{1'b0}}, status_i};
      SRC_SIG:    pick = sig_i;
      SRC_QUERY:  pick = query_i;
      default:    pick = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q <= '0;
      oe_q <= 1'b0;
    end else begin
      oe_q <= drive_i;
      dq_q <= drive_i ? pick : '0;
    end
  end

  assign dq_o = dq_q;
  assign oe_o = oe_q;

  // R2: nothing on the bus value while not driving
  assert_quiet_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> (dq_q == '0));
  // R3: status puts zeros above the low byte
  assert_status_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && $past(src_i) == SRC_STATUS) |-> (dq_q[DW-1:SW] == '0));
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front #(
  parameter int AW = 19,
  parameter int DW = 32,
  parameter int SW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_cs_n,
  input  logic          pin_oe_n,
  input  logic          pin_od_n,
  input  logic          pin_we_n,
  input  logic          pin_le_n,
  input  logic          pin_bclk,
  input  logic          pin_rst_n,
  input  logic [AW-1:0] pin_addr,
  input  logic [DW-1:0] pin_dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [1:0]    out_sel,
  input  logic [DW-1:0] arr_data,
  input  logic [SW-1:0] status_byte,
  input  logic [DW-1:0] sig_data,
  input  logic [DW-1:0] query_data,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  import flash_bus_pkg::*;
  localparam int BUS_W = AW + DW;

  logic [CTL_W-1:0] ctl_raw, s_ctl, p_ctl;
  logic [BUS_W-1:0] s_bus;
  logic [AW-1:0]    s_addr, cur_addr;
  logic [DW-1:0]    s_dq;

  assign ctl_raw = {pin_rst_n, pin_bclk, pin_le_n, pin_we_n, pin_od_n, pin_oe_n, pin_cs_n};

  fbi_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ctl_raw), .q_o(s_ctl));

  fbi_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d_i({pin_addr, pin_dq_in}), .q_o(s_bus));

  assign s_addr = s_bus[BUS_W-1:DW];
  assign s_dq   = s_bus[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_ctl <= CTL_IDLE;
    else        p_ctl <= s_ctl;
  end

  logic live, cs_low, we_low, le_low, drive;
  logic cs_rise, cs_fall, we_rise, le_rise, le_fall, k_rise;
  logic wr_ctx, wr_done;

  assign live    = s_ctl[CTL_RST];
  assign cs_low  = ~s_ctl[CTL_CS];
  assign we_low  = ~s_ctl[CTL_WE];
  assign le_low  = ~s_ctl[CTL_LE];
  assign cs_rise = s_ctl[CTL_CS] & ~p_ctl[CTL_CS];
  assign cs_fall = ~s_ctl[CTL_CS] & p_ctl[CTL_CS];
  assign we_rise = s_ctl[CTL_WE] & ~p_ctl[CTL_WE];
  assign le_rise = s_ctl[CTL_LE] & ~p_ctl[CTL_LE];
  assign le_fall = ~s_ctl[CTL_LE] & p_ctl[CTL_LE];
  assign k_rise  = s_ctl[CTL_K] & ~p_ctl[CTL_K];
  assign drive   = live & cs_low & ~s_ctl[CTL_OE] & s_ctl[CTL_OD];

  fbi_addr_latch #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .live_i(live), .pins_i(s_addr),
    .cs_low_i(cs_low), .le_low_i(le_low), .le_rise_i(le_rise), .le_fall_i(le_fall),
    .k_rise_i(k_rise), .cs_rise_i(cs_rise), .cs_fall_i(cs_fall), .we_rise_i(we_rise),
    .wr_ctx_i(wr_ctx), .wr_done_i(wr_done), .addr_o(rd_addr), .cur_addr_o(cur_addr));

  fbi_write_capture #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .live_i(live), .cs_low_i(cs_low), .we_low_i(we_low),
    .we_rise_i(we_rise), .cs_rise_i(cs_rise), .cur_addr_i(cur_addr), .dq_i(s_dq),
    .wr_ctx_o(wr_ctx), .wr_done_o(wr_done), .cmd_valid_o(cmd_valid),
    .cmd_ready_i(cmd_ready), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data));

  fbi_out_mux #(.DW(DW), .SW(SW)) u_out (
    .clk(clk), .rst_n(rst_n), .drive_i(drive), .src_i(out_src_e'(out_sel)),
    .arr_i(arr_data), .status_i(status_byte), .sig_i(sig_data), .query_i(query_data),
    .dq_o(dq_out), .oe_o(dq_oe));

  // R10: reset pin low silences the bus on the next cycle
  assert_no_drive_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> !dq_oe);
  // R10: reset pin low drops any waiting command
  assert_no_cmd_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> !cmd_valid);
  // R1: output disable low on its own blocks driving
  assert_od_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ctl[CTL_OD] |=> !dq_oe);
endmodule

// File: tb/flash_bus_front_tb.sv
module flash_bus_front_tb;
  localparam int AW = 19;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_cs_n = 1, pin_oe_n = 1, pin_od_n = 1, pin_we_n = 1;
  logic pin_le_n = 1, pin_bclk = 0, pin_rst_n = 1;
  logic [AW-1:0] pin_addr = '0;
  logic [DW-1:0] pin_dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;
  logic [AW-1:0] rd_addr;
  logic [1:0] out_sel = 2'd0;
  logic [DW-1:0] arr_data = '0, sig_data = '0, query_data = '0;
  logic [7:0] status_byte = '0;
  logic cmd_valid;
  logic cmd_ready = 1'b0;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_bus_front u_dut (
    .clk(clk), .rst_n(rst_n), .pin_cs_n(pin_cs_n), .pin_oe_n(pin_oe_n),
    .pin_od_n(pin_od_n), .pin_we_n(pin_we_n), .pin_le_n(pin_le_n), .pin_bclk(pin_bclk),
    .pin_rst_n(pin_rst_n), .pin_addr(pin_addr), .pin_dq_in(pin_dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .rd_addr(rd_addr), .out_sel(out_sel),
    .arr_data(arr_data), .status_byte(status_byte), .sig_data(sig_data),
    .query_data(query_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_oe(logic cs, logic oe, logic od, logic rp);
    return rp && !cs && !oe && od;
  endfunction

  function automatic logic [DW-1:0] exp_dq(logic drv, logic [1:0] sel, logic [DW-1:0] a,
                                           logic [7:0] st, logic [DW-1:0] sg, logic [DW-1:0] q);
    if (!drv) return '0;
    case (sel)
      2'd0: return a;
      2'd1: return {24'd0, st};
      2'd2: return sg;
      default: return q;
    endcase
  endfunction

  task automatic accept();
    cmd_ready = 1'b1; tick(1); cmd_ready = 1'b0; tick(1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a0, a1, a2;
    logic [DW-1:0] d0, d1;
    void'($urandom(32'h5eed1234));
    tick(3); rst_n = 1'b1; tick(6);
    chk("R2 reset dq_oe", dq_oe, 0);
    chk("R2 reset dq_out", dq_out, 0);
    chk("R9 reset cmd_valid", cmd_valid, 0);

    // R1 R2 R3: random pin and source sweep
    for (int i = 0; i < 48; i++) begin
      pin_cs_n = 1'($urandom); pin_oe_n = 1'($urandom); pin_od_n = 1'($urandom);
      pin_rst_n = ($urandom % 4) != 0;
      out_sel = 2'($urandom); arr_data = $urandom; status_byte = 8'($urandom);
      sig_data = $urandom; query_data = $urandom;
      tick(5);
      chk("R1 drive", dq_oe, exp_oe(pin_cs_n, pin_oe_n, pin_od_n, pin_rst_n));
      chk("R3 data", dq_out, exp_dq(exp_oe(pin_cs_n, pin_oe_n, pin_od_n, pin_rst_n),
                                   out_sel, arr_data, status_byte, sig_data, query_data));
    end
    // R3: directed status with all ones, one-clock select follow
    pin_cs_n = 0; pin_oe_n = 0; pin_od_n = 1; pin_rst_n = 1;
    status_byte = 8'hff; arr_data = 32'hffff_ffff; out_sel = 2'd1; tick(5);
    chk("R3 status pad", dq_out, 32'h0000_00ff);
    out_sel = 2'd0; tick(1);
    chk("R3 select follows in one clock", dq_out, 32'hffff_ffff);
    pin_od_n = 0; tick(5);
    chk("R1 od alone blocks", dq_oe, 0);
    chk("R2 zero when off", dq_out, 0);
    pin_od_n = 1; pin_oe_n = 1; pin_cs_n = 1; tick(5);

    // R4 R5: read latch behaviour
    pin_cs_n = 0; pin_le_n = 0; a0 = 19'($urandom); pin_addr = a0; tick(5);
    chk("R4 transparent", rd_addr, a0);
    a1 = a0 ^ 19'h2a5a5; pin_addr = a1; tick(5);
    chk("R4 follows", rd_addr, a1);
    pin_le_n = 1; tick(2); a2 = a1 ^ 19'h7ffff; pin_addr = a2; tick(5);
    chk("R5 le rise locks", rd_addr, a1);
    pin_le_n = 0; tick(5);
    chk("R5 le fall unlocks", rd_addr, a2);
    pin_bclk = 1; tick(2); pin_addr = a0; tick(5);
    chk("R5 burst clock locks", rd_addr, a2);
    pin_bclk = 0; pin_cs_n = 1; tick(3); pin_cs_n = 0; tick(5);
    chk("R5 cs fall unlocks", rd_addr, a0);
    pin_cs_n = 1; tick(4);

    // R7 R9: write via WE, back-pressure, drop, accept
    pin_le_n = 0; a0 = 19'($urandom); d0 = $urandom;
    pin_addr = a0; pin_dq_in = d0; pin_cs_n = 0; tick(2);
    pin_we_n = 0; tick(3); pin_we_n = 1; tick(5);
    chk("R7 valid", cmd_valid, 1);
    chk("R7 addr", cmd_addr, a0);
    chk("R7 data", cmd_data, d0);
    pin_dq_in = ~d0; pin_we_n = 0; tick(3); pin_we_n = 1; tick(5);
    chk("R9 held data", cmd_data, d0);
    chk("R9 held valid", cmd_valid, 1);
    accept();
    chk("R9 retire after accept", cmd_valid, 0);
    // R11: lock released after write, LE still low
    a1 = a0 ^ 19'h15555; pin_addr = a1; tick(5);
    chk("R11 transparent again", rd_addr, a1);
    pin_cs_n = 1; tick(4);

    // R6: LE rise locks address before WE ends the write
    a0 = 19'($urandom); d1 = $urandom; pin_addr = a0; pin_dq_in = d1;
    pin_cs_n = 0; tick(2); pin_we_n = 0; tick(3);
    pin_le_n = 1; tick(2); pin_addr = ~a0; tick(3); pin_we_n = 1; tick(5);
    chk("R6 early address", cmd_addr, a0);
    chk("R6 data", cmd_data, d1);
    accept();
    pin_cs_n = 1; pin_le_n = 0; tick(4);

    // R7: write ended by chip enable
    a0 = 19'($urandom); d0 = $urandom; pin_addr = a0; pin_dq_in = d0;
    pin_cs_n = 0; tick(2); pin_we_n = 0; tick(3); pin_cs_n = 1; tick(3);
    pin_dq_in = ~d0; pin_we_n = 1; tick(5);
    chk("R7 cs end data", cmd_data, d0);
    chk("R6 cs end addr", cmd_addr, a0);
    accept();

    // R8: simultaneous edges give one command
    pin_cs_n = 0; tick(2); pin_we_n = 0; tick(3);
    pin_we_n = 1; pin_cs_n = 1; tick(5);
    chk("R8 one valid", cmd_valid, 1);
    accept();
    tick(4);
    chk("R8 no second command", cmd_valid, 0);

    // R10: reset pin drops command, blocks writes and drive
    pin_cs_n = 0; tick(2); pin_we_n = 0; tick(3); pin_we_n = 1; tick(5);
    chk("R10 pending before reset", cmd_valid, 1);
    pin_oe_n = 0; pin_rst_n = 0; tick(5);
    chk("R10 command dropped", cmd_valid, 0);
    chk("R10 no drive", dq_oe, 0);
    pin_we_n = 0; tick(3); pin_we_n = 1; tick(5);
    pin_rst_n = 1; tick(5);
    chk("R10 write ignored", cmd_valid, 0);
    chk("R1 drive resumes", dq_oe, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule